// File: doc/BRIEF.md
# Sound Generator Bus Bridge

This block connects a 16-bit processor bus to an 8-bit programmable sound generator that is steered by three control lines: a direction line plus two bus-control lines, called here `psgDir`, `psgCtl2` and `psgCtl1`. The bridge claims a 256-byte window in the I/O page. Every even address in that window reaches the same generator, so the window works as a set of mirrors. Address bit 1 picks the kind of write: with the bit clear, the write selects a generator register; with it set, the write stores the data byte into the selected register. Reads return the generator's data on the upper byte lane.

Each claimed access waits first for any alignment delay the bus reports. The bridge then drives the generator's control lines and data byte for exactly one clock, holds for a fixed wait, and then acknowledges. The acknowledge stays high until the processor drops its address strobe. The bridge also turns the generator's active-low output port A into active-high floppy drive-select and side-select signals.

Top module: `psg_bus_bridge`

## Requirements
- R1: With the default parameters the bridge claims word addresses whose byte address lies between 0xFF8800 and 0xFF88FE. All of them reach the same generator. Any other address produces no control-line activity and no acknowledge.
- R2: A read drives the control code {psgDir,psgCtl2,psgCtl1} = 3'b011 for one clock. During the acknowledge it returns the byte sampled from `psgDataIn` on `busRdData[15:8]`, with `busRdData[7:0]` = 8'hFF.
- R3: A write with `busAddr[1]` = 0 drives the code 3'b111 for one clock, with `psgDataOut` equal to `busWrData[15:8]`. This latches the register number.
- R4: A write with `busAddr[1]` = 1 drives the code 3'b110 for one clock, with `psgDataOut` equal to `busWrData[15:8]`. This stores the value in the selected register.
- R5: Count falling edges from the one at which a claimed request is first presented. The drive cycle appears at count `alignWait`+2, and `busDtack` rises at count `alignWait`+2+1+WAIT_CYCLES (default WAIT_CYCLES = 2). `busDtack` stays high until `busAs` falls, and it is low one cycle after `busAs` falls.
- R6: Outside the drive cycle the control code is 3'b000, `psgDataOut` is 0 and `busRdData` is 0. Only the codes 011, 111 and 110 ever appear.
- R7: Two drive cycles are always separated by at least one clock with the code 3'b000.
- R8: A claimed address presented with `busDs` low causes no chip operation and no acknowledge.
- R9: `drive0Sel` = NOT `portA[1]`, `drive1Sel` = NOT `portA[2]`, and `side1Sel` = NOT `portA[0]`.
- R10: While `rstN` is low and right after it is released, the control code is 000, `busDtack` is 0 and `busRdData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 23 | Word address, byte address bits 23:1 |
| busAs | input | 1 | Address strobe, held for the whole access |
| busDs | input | 1 | Data strobe active |
| busRnW | input | 1 | 1 = read, 0 = write |
| busWrData | input | 16 | Write data; the generator uses bits 15:8 |
| alignWait | input | 3 | Alignment delay in clocks already owed by this access |
| busRdData | output | 16 | Read data during the acknowledge |
| busDtack | output | 1 | Data acknowledge |
| psgDir | output | 1 | Generator direction control line |
| psgCtl2 | output | 1 | Generator bus control line 2 |
| psgCtl1 | output | 1 | Generator bus control line 1 |
| psgDataOut | output | 8 | Byte driven to the generator |
| psgDataIn | input | 8 | Byte returned by the generator |
| portA | input | 8 | Generator output port A, active low |
| drive0Sel | output | 1 | Floppy drive 0 selected |
| drive1Sel | output | 1 | Floppy drive 1 selected |
| side1Sel | output | 1 | Floppy side 1 selected |

## Verification
The bench presents each request just after a falling edge and then counts falling edges. The drive cycle is expected at count `alignWait`+2 and the acknowledge at `alignWait`+5. The bench records both counts on every access and compares them with those formulas, so a wrong alignment or a wrong fixed wait shows up as an off-by-one count. Read data and the driven byte are captured at the edges where the drive and the acknowledge are due. The bench also runs a small register model of the generator, clocked by the control lines, so each read result depends on the earlier selects and writes made through the mirrors. The port A decode is combinational and is sampled one time step after each new `portA` value.

// File: rtl/psgb_pkg.sv
package psgb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_DRIVE,
    ST_HOLD,
    ST_ACK
  } state_t;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_SELECT = 2'd1,
    OP_STORE  = 2'd2
  } op_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch operation and write byte
    logic drive;    // present control code to the generator
    logic ack;      // acknowledge phase
  } strobe_t;

  // control codes {dir, ctl2, ctl1}
  localparam logic [2:0] CODE_IDLE   = 3'b000;
  localparam logic [2:0] CODE_READ   = 3'b011;
  localparam logic [2:0] CODE_SELECT = 3'b111;
  localparam logic [2:0] CODE_STORE  = 3'b110;

endpackage

// File: rtl/psgb_decode.sv
module psgb_decode #(
  parameter int ADDR_W   = 24,
  parameter int WIN_LOG2 = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 24'hFF8800
) (
  input  logic [ADDR_W-1:1] busAddr,
  input  logic              busRnW,
  output logic              hit,
  output psgb_pkg::op_t     opKind
);
  import psgb_pkg::*;

  assign hit = (busAddr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);

  always_comb begin
    if (busRnW)          opKind = OP_READ;
    else if (busAddr[1]) opKind = OP_STORE;
    else                 opKind = OP_SELECT;
  end
endmodule

// File: rtl/psgb_ctrl.sv
module psgb_ctrl #(
  parameter int ALIGN_W     = 3,
  parameter int WAIT_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               request,
  input  logic               busAs,
  input  logic [ALIGN_W-1:0] alignWait,
  output psgb_pkg::strobe_t  strobes
);
  import psgb_pkg::*;

  localparam int WAIT_W = $clog2(WAIT_CYCLES + 1);
  localparam int CNT_W  = (ALIGN_W > WAIT_W) ? ALIGN_W : WAIT_W;

  state_t            state;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (request) begin
          state <= ST_ALIGN;
          cnt   <= CNT_W'(alignWait);
        end
        ST_ALIGN: begin
          if (cnt == '0) state <= ST_DRIVE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_DRIVE: begin
          state <= ST_HOLD;
          cnt   <= CNT_W'(WAIT_CYCLES - 1);
        end
        ST_HOLD: begin
          if (cnt == '0) state <= ST_ACK;
          else           cnt   <= cnt - 1'b1;
        end
        ST_ACK: if (!busAs) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.capture = (state == ST_IDLE) && request;
    strobes.drive   = (state == ST_DRIVE);
    strobes.ack     = (state == ST_ACK);
  end
endmodule

// File: rtl/psgb_dpath.sv
module psgb_dpath #(
  parameter int BUS_W  = 16,
  parameter int CHIP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  psgb_pkg::strobe_t strobes,
  input  psgb_pkg::op_t     opKind,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic [CHIP_W-1:0] psgDataIn,
  input  logic [CHIP_W-1:0] portA,
  output logic [BUS_W-1:0]  busRdData,
  output logic [2:0]        ctlCode,
  output logic [CHIP_W-1:0] psgDataOut,
  output logic              drive0Sel,
  output logic              drive1Sel,
  output logic              side1Sel
);
  import psgb_pkg::*;

  localparam int LOW_W = BUS_W - CHIP_W;

  op_t               opReg;
  logic [CHIP_W-1:0] wrByte;
  logic [CHIP_W-1:0] rdByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg  <= OP_READ;
      wrByte <= '0;
      rdByte <= '0;
    end else begin
      if (strobes.capture) begin
        opReg  <= opKind;
        wrByte <= busWrData[BUS_W-1:LOW_W];
      end
      if (strobes.drive && opReg == OP_READ) rdByte <= psgDataIn;
    end
  end

  always_comb begin
    ctlCode = CODE_IDLE;
    if (strobes.drive) begin
      unique case (opReg)
        OP_READ:   ctlCode = CODE_READ;
        OP_SELECT: ctlCode = CODE_SELECT;
        OP_STORE:  ctlCode = CODE_STORE;
        default:   ctlCode = CODE_IDLE;
      endcase
    end
  end

  assign psgDataOut = (strobes.drive && opReg != OP_READ) ? wrByte : '0;
  assign busRdData  = (strobes.ack && opReg == OP_READ) ? {rdByte, {LOW_W{1'b1}}} : '0;

  // port A lines are active low
  assign drive0Sel = ~portA[1];
  assign drive1Sel = ~portA[2];
  assign side1Sel  = ~portA[0];
endmodule

// File: rtl/psg_bus_bridge.sv
module psg_bus_bridge #(
  parameter int ADDR_W      = 24,
  parameter int WIN_LOG2    = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 24'hFF8800,
  parameter int BUS_W       = 16,
  parameter int CHIP_W      = 8,
  parameter int ALIGN_W     = 3,
  parameter int WAIT_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:1]  busAddr,
  input  logic               busAs,
  input  logic               busDs,
  input  logic               busRnW,
  input  logic [BUS_W-1:0]   busWrData,
  input  logic [ALIGN_W-1:0] alignWait,
  output logic [BUS_W-1:0]   busRdData,
  output logic               busDtack,
  output logic               psgDir,
  output logic               psgCtl2,
  output logic               psgCtl1,
  output logic [CHIP_W-1:0]  psgDataOut,
  input  logic [CHIP_W-1:0]  psgDataIn,
  input  logic [CHIP_W-1:0]  portA,
  output logic               drive0Sel,
  output logic               drive1Sel,
  output logic               side1Sel
);
  import psgb_pkg::*;

  logic      hit;
  op_t       opKind;
  strobe_t   strobes;
  logic [2:0] ctlCode;

  psgb_decode #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE)) u_dec (
    .busAddr(busAddr), .busRnW(busRnW), .hit(hit), .opKind(opKind));

  psgb_ctrl #(.ALIGN_W(ALIGN_W), .WAIT_CYCLES(WAIT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .request(hit && busAs && busDs), .busAs(busAs),
    .alignWait(alignWait), .strobes(strobes));

  psgb_dpath #(.BUS_W(BUS_W), .CHIP_W(CHIP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opKind(opKind),
    .busWrData(busWrData), .psgDataIn(psgDataIn), .portA(portA),
    .busRdData(busRdData), .ctlCode(ctlCode), .psgDataOut(psgDataOut),
    .drive0Sel(drive0Sel), .drive1Sel(drive1Sel), .side1Sel(side1Sel));

  assign {psgDir, psgCtl2, psgCtl1} = ctlCode;
  assign busDtack = strobes.ack;
endmodule

// File: rtl/psgb_chk.sv
module psgb_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:1] busAddr,
  input logic              busAs,
  input logic              busRnW,
  input logic              busDtack,
  input logic              psgDir,
  input logic              psgCtl2,
  input logic              psgCtl1
);
  // R6: any active control line implies a legal code (ctl2 always high)
  a_r6_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    (psgDir || psgCtl1) |-> psgCtl2);

  // R7: a drive cycle is followed by an idle one
  a_r7_idle_gap: assert property (@(posedge clk) disable iff (!rstN)
    psgCtl2 |=> !psgCtl2);

  // R2: read code only on a read access
  a_r2_read_code: assert property (@(posedge clk) disable iff (!rstN)
    (psgCtl2 && psgCtl1 && !psgDir) |-> busRnW);

  // R3: select code only with address bit 1 clear on a write
  a_r3_select_code: assert property (@(posedge clk) disable iff (!rstN)
    (psgDir && psgCtl1) |-> (!busAddr[1] && !busRnW));

  // R4: store code only with address bit 1 set
  a_r4_store_code: assert property (@(posedge clk) disable iff (!rstN)
    (psgDir && !psgCtl1 && psgCtl2) |-> busAddr[1]);

  // R5: acknowledge never rises straight out of a drive cycle
  a_r5_wait_before_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busDtack) |-> !$past(psgCtl2));

  // R5: acknowledge only while the access strobe was present
  a_r5_ack_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    busDtack |-> $past(busAs));
endmodule

bind psg_bus_bridge psgb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busAs(busAs), .busRnW(busRnW),
  .busDtack(busDtack), .psgDir(psgDir), .psgCtl2(psgCtl2), .psgCtl1(psgCtl1));

// File: tb/sim_psg_bus_bridge.sv
module sim_psg_bus_bridge;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:1] busAddr = '0;
  logic        busAs = 1'b0, busDs = 1'b0, busRnW = 1'b1;
  logic [15:0] busWrData = '0;
  logic [2:0]  alignWait = '0;
  logic [15:0] busRdData;
  logic        busDtack, psgDir, psgCtl2, psgCtl1;
  logic [7:0]  psgDataOut, psgDataIn;
  logic [7:0]  portA = 8'hFF;
  logic        drive0Sel, drive1Sel, side1Sel;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psg_bus_bridge u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busAs(busAs), .busDs(busDs),
    .busRnW(busRnW), .busWrData(busWrData), .alignWait(alignWait),
    .busRdData(busRdData), .busDtack(busDtack), .psgDir(psgDir),
    .psgCtl2(psgCtl2), .psgCtl1(psgCtl1), .psgDataOut(psgDataOut),
    .psgDataIn(psgDataIn), .portA(portA), .drive0Sel(drive0Sel),
    .drive1Sel(drive1Sel), .side1Sel(side1Sel));

  // small generator register model driven by the control lines
  logic [7:0] regs [16];
  logic [3:0] selReg = '0;
  assign psgDataIn = regs[selReg];
  initial for (int i = 0; i < 16; i++) regs[i] = 8'(i * 17);
  always @(posedge clk) begin
    if ({psgDir, psgCtl2, psgCtl1} == 3'b111) selReg <= psgDataOut[3:0];
    if ({psgDir, psgCtl2, psgCtl1} == 3'b110) regs[selReg] <= psgDataOut;
  end

  // idle-gap monitor over the whole run
  logic prevActive = 1'b0;
  int   gapErrors = 0;
  always @(negedge clk) begin
    if (prevActive && psgCtl2) gapErrors++;
    prevActive <= psgCtl2;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {addr24, rnw, data8, align3, expected read byte}
  localparam logic [43:0] VEC [NVEC] = '{
    {24'hFF8800, 1'b0, 8'h03, 3'd0, 8'h00},
    {24'hFF8802, 1'b0, 8'hA5, 3'd1, 8'h00},
    {24'hFF8800, 1'b1, 8'h00, 3'd0, 8'hA5},
    {24'hFF88F0, 1'b0, 8'h07, 3'd2, 8'h00},
    {24'hFF88FE, 1'b0, 8'h3C, 3'd0, 8'h00},
    {24'hFF8876, 1'b1, 8'h00, 3'd3, 8'h3C},
    {24'hFF8840, 1'b0, 8'h03, 3'd0, 8'h00},
    {24'hFF88A2, 1'b1, 8'h00, 3'd1, 8'hA5}
  };

  task automatic access(input logic [23:0] a, input bit rnw, input logic [7:0] d,
                        input logic [2:0] al, output int drvK, output int ackK,
                        output int drvCnt, output logic [2:0] code,
                        output logic [7:0] drvOut, output logic [15:0] rd);
    drvK = -1; ackK = -1; drvCnt = 0; code = '0; drvOut = '0; rd = '0;
    busAddr = a[23:1]; busRnW = rnw; busWrData = {d, 8'h5A}; alignWait = al;
    busAs = 1'b1; busDs = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (psgCtl2 || psgDir || psgCtl1) begin
        drvCnt++; drvK = k; code = {psgDir, psgCtl2, psgCtl1}; drvOut = psgDataOut;
      end
      if (busDtack) begin ackK = k; rd = busRdData; break; end
    end
    busAs = 1'b0; busDs = 1'b0;
    @(negedge clk);
  endtask

  task automatic noAccess(input logic [23:0] a, input bit ds, input string req);
    int seen = 0;
    busAddr = a[23:1]; busRnW = 1'b0; busWrData = 16'hFF00; alignWait = '0;
    busAs = 1'b1; busDs = ds;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (busDtack || psgCtl2 || psgDir || psgCtl1) seen++;
    end
    busAs = 1'b0; busDs = 1'b0;
    @(negedge clk);
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    int drvK, ackK, drvCnt;
    logic [2:0] code, expCode;
    logic [7:0] drvOut;
    logic [15:0] rd;

    repeat (3) @(negedge clk);
    // R10: reset state, during and right after reset
    check({busDtack, psgDir, psgCtl2, psgCtl1} == 4'b0 && busRdData == 16'h0,
          "R10 during reset", {busDtack, psgDir, psgCtl2, psgCtl1}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({busDtack, psgDir, psgCtl2, psgCtl1} == 4'b0 && busRdData == 16'h0,
          "R10 after reset", busRdData, 0);

    // vector table: R1 mirrors, R2 read, R3 select, R4 store, R5 timing
    for (int v = 0; v < NVEC; v++) begin
      logic [23:0] a; logic rnw; logic [7:0] d, e; logic [2:0] al;
      {a, rnw, d, al, e} = VEC[v];
      access(a, rnw, d, al, drvK, ackK, drvCnt, code, drvOut, rd);
      expCode = rnw ? 3'b011 : (a[1] ? 3'b110 : 3'b111);
      check(drvCnt == 1, "R6 single drive cycle", drvCnt, 1);
      check(code == expCode, rnw ? "R2 read code" : (a[1] ? "R4 store code" : "R3 select code"),
            code, expCode);
      check(drvK == al + 2, "R5 drive cycle position", drvK, al + 2);
      check(ackK == al + 5, "R5 acknowledge position", ackK, al + 5);
      check(busDtack == 1'b0, "R5 ack released after strobe", busDtack, 0);
      if (rnw) begin
        check(rd == {e, 8'hFF}, "R2 R1 read data through mirror", rd, {e, 8'hFF});
        check(drvOut == 8'h00, "R6 no data out on read", drvOut, 0);
      end else begin
        check(drvOut == d, a[1] ? "R4 store byte" : "R3 select byte", drvOut, d);
      end
    end

    // R1: outside the window is ignored
    noAccess(24'hFF8900, 1'b1, "R1 address above window ignored");
    noAccess(24'hFF87FE, 1'b1, "R1 address below window ignored");
    noAccess(24'hFE8800, 1'b1, "R1 other page ignored");
    // R8: no data strobe, no chip operation
    noAccess(24'hFF8802, 1'b0, "R8 no data strobe");
    // R8: confirm register 3 unchanged by the suppressed write
    access(24'hFF8800, 1'b1, 8'h00, 3'd0, drvK, ackK, drvCnt, code, drvOut, rd);
    check(rd == 16'hA5FF, "R8 register untouched", rd, 16'hA5FF);

    // R7: accesses back to back
    check(gapErrors == 0, "R7 idle gap between drives", gapErrors, 0);

    // R9: port A decode
    for (int p = 0; p < 5; p++) begin
      logic [7:0] pv;
      pv = (p == 0) ? 8'hFF : (p == 1) ? 8'hFD : (p == 2) ? 8'hFB : (p == 3) ? 8'hFE : 8'h00;
      portA = pv;
      #1;
      check({drive0Sel, drive1Sel, side1Sel} == {~pv[1], ~pv[2], ~pv[0]},
            "R9 port A decode", {drive0Sel, drive1Sel, side1Sel}, {~pv[1], ~pv[2], ~pv[0]});
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule